// File: doc/BRIEF.md
# Two-Wire Configuration Register Target

This block is an I2C target that gives a host read and write access to a small bank of 8-bit configuration registers. The SCL and SDA pad inputs are oversampled on a fast system clock, pass through synchronizers, and are turned into edge events. SDA is driven through an open-drain enable: when `sda_oe_o` is high the pad pulls the line low, and otherwise the line is released. Clock stretching is not used. Only the standard and fast timing family is handled.

The 7-bit device address has a fixed upper part. Two strap inputs fill in the middle bits, so four instances can share one bus. In a write transfer, the first data byte loads an internal register pointer. Each later byte is stored at the pointer, and the pointer then advances. A read transfer returns bytes starting at the current pointer and advances the pointer after each byte. A repeated START keeps the pointer, so the usual sequence of setting the pointer and then reading with a repeated START works. Pointer values that have no register behind them read back as zero and absorb writes.

Top module: `i2c_tgt_regs`

## Requirements
- R1: After reset, `sda_oe_o` is low and register i holds 8'hA0 + i. `cfg_o[8i+7:8i]` always reflects register i.
- R2: A falling SDA while SCL is high is taken as START, and a rising SDA while SCL is high is taken as STOP. Both are recognised in every state. A byte cut short by either is discarded without any register write.
- R3: The target acknowledges a first byte whose upper seven bits are 1,0,0,1,`strap_i[1]`,`strap_i[0]`,0 (MSB first). Bit 0 of that byte selects the direction: 0 is a host write and 1 is a host read. It acknowledges by pulling SDA low for the whole high phase of the ninth SCL pulse.
- R4: Any other address is never acknowledged. This includes general call 7'b0000000 and the 10-bit prefix 7'b11110xx. After a mismatch the target drives nothing and writes nothing until the next START.
- R5: In a write transfer, the first data byte sets the 8-bit pointer. Each later byte writes register[pointer], and the pointer then increments, wrapping from 255 to 0. Every data byte is acknowledged.
- R6: Writes to pointer values of NUM_REGS and above are acknowledged and change no register.
- R7: In a read transfer, bytes are sent MSB first from register[pointer], and the pointer increments after each byte. SDA is released in the host's acknowledge slot. A host ACK (SDA low) causes the next byte to be sent. A host NACK stops all driving until START or STOP.
- R8: Reading a pointer value of NUM_REGS or above returns 8'h00.
- R9: A repeated START restarts address reception and keeps the pointer.
- R10: The SDA drive changes only while SCL is low, and stays constant across each SCL high phase.
- R11: After STOP the target is idle. SCL pulses without a new START get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 8x the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad input |
| sda_i | input | 1 | SDA pad input (resolved line level) |
| strap_i | input | 2 | Address strap bits, placed at address bits 2:1 |
| sda_oe_o | output | 1 | Open-drain enable; high pulls SDA low |
| cfg_o | output | NUM_REGS*8 | Flattened register bank, register i at [8i+7:8i] |

## Verification
A wrong bit counter or a wrong protocol state shows up at the ports within one byte. The acknowledge lands on the wrong SCL pulse, appears when it should not, or is missing. In every case the host sees a changed ack bit within nine SCL periods. A wrong pointer shows up only at the next register access: either `cfg_o` changes in the wrong field right after the ninth bit of a write, or a read returns a neighbouring register's value. The directed sequences are therefore written so that every write is followed by a read-back through the bus or a compare of `cfg_o`. SDA is sampled both early and late in each high phase, so a drive that changes mid-pulse is caught on the bit where it happens.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_WRITE,
    S_WRITE_ACK,
    S_READ,
    S_READ_ACK,
    S_IGNORE
  } tgt_state_e;

  localparam logic [3:0] ADDR_HI = 4'b1001;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 8;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic prev_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= line_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign prev_o  = prev_q;

endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [DATA_W-1:0] RST_BASE = 8'hA0
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          waddr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [ADDR_W-1:0]          raddr_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(NUM_REGS);

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_q[i] <= DATA_W'(RST_BASE + i);
      else if (we_i && waddr_i == ADDR_W'(i))      regs_q[i] <= wdata_i;
    end
    assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];

    p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && waddr_i == ADDR_W'(i)) |=> (regs_o[i*DATA_W +: DATA_W] == $past(wdata_i)));
  end

  // unlisted addresses fall through to zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == ADDR_W'(i)) rdata_o = regs_q[i];
    end
  end

  p_unimpl_write_dropped_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i >= TOP_ADDR) |=> $stable(regs_o));

  p_unimpl_read_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raddr_i >= TOP_ADDR) |-> (rdata_o == '0));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              scl_prev_i,
  input  logic              sda_i,
  input  logic              sda_prev_i,
  input  logic [1:0]        strap_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              we_o,
  output logic [PTR_W-1:0]  waddr_o,
  output logic [BYTE_W-1:0] wdata_o,
  output logic              sda_oe_o
);

  tgt_state_e        st_q;
  logic [2:0]        cnt_q;
  logic [BYTE_W-1:0] sh_q, tx_q, wd_q;
  logic [PTR_W-1:0]  ptr_q, wa_q;
  logic              oe_q, first_q, rw_q, done_q, hack_q, we_q;

  logic       start_det, stop_det, scl_rise, scl_fall;
  logic [6:0] dev_addr;

  assign start_det = scl_i & scl_prev_i & sda_prev_i & ~sda_i;
  assign stop_det  = scl_i & scl_prev_i & ~sda_prev_i & sda_i;
  assign scl_rise  = scl_i & ~scl_prev_i;
  assign scl_fall  = ~scl_i & scl_prev_i;
  assign dev_addr  = {ADDR_HI, strap_i, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      wd_q    <= '0;
      wa_q    <= '0;
      ptr_q   <= '0;
      oe_q    <= 1'b0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      done_q  <= 1'b0;
      hack_q  <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (stop_det) begin
        st_q   <= S_IDLE;
        oe_q   <= 1'b0;
        done_q <= 1'b0;
      end else if (start_det) begin
        st_q   <= S_ADDR;
        cnt_q  <= '0;
        oe_q   <= 1'b0;
        done_q <= 1'b0;
      end else begin
        unique case (st_q)
          S_ADDR, S_WRITE: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) done_q <= 1'b1;
            end else if (scl_fall && done_q) begin
              done_q <= 1'b0;
              if (st_q == S_ADDR) begin
                if (sh_q[7:1] == dev_addr) begin
                  oe_q <= 1'b1;
                  rw_q <= sh_q[0];
                  st_q <= S_ADDR_ACK;
                end else begin
                  st_q <= S_IGNORE;
                end
              end else begin
                oe_q <= 1'b1;
                st_q <= S_WRITE_ACK;
                if (first_q) begin
                  ptr_q   <= sh_q;
                  first_q <= 1'b0;
                end else begin
                  we_q  <= 1'b1;
                  wa_q  <= ptr_q;
                  wd_q  <= sh_q;
                  ptr_q <= ptr_q + 1'b1;
                end
              end
            end
          end
          S_ADDR_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                st_q <= S_READ;
                tx_q <= {rdata_i[BYTE_W-2:0], 1'b0};
                oe_q <= ~rdata_i[BYTE_W-1];
              end else begin
                st_q    <= S_WRITE;
                oe_q    <= 1'b0;
                first_q <= 1'b1;
              end
            end
          end
          S_WRITE_ACK: begin
            if (scl_fall) begin
              oe_q  <= 1'b0;
              cnt_q <= '0;
              st_q  <= S_WRITE;
            end
          end
          S_READ: begin
            if (scl_rise) begin
              cnt_q <= cnt_q + 3'd1;
              if (cnt_q == 3'd7) done_q <= 1'b1;
            end else if (scl_fall) begin
              if (done_q) begin
                done_q <= 1'b0;
                oe_q   <= 1'b0;
                ptr_q  <= ptr_q + 1'b1;
                st_q   <= S_READ_ACK;
              end else begin
                oe_q <= ~tx_q[BYTE_W-1];
                tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
              end
            end
          end
          S_READ_ACK: begin
            if (scl_rise) begin
              hack_q <= ~sda_i;
            end else if (scl_fall) begin
              if (hack_q) begin
                st_q  <= S_READ;
                cnt_q <= '0;
                tx_q  <= {rdata_i[BYTE_W-2:0], 1'b0};
                oe_q  <= ~rdata_i[BYTE_W-1];
              end else begin
                st_q <= S_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o    = ptr_q;
  assign we_o     = we_q;
  assign waddr_o  = wa_q;
  assign wdata_o  = wd_q;
  assign sda_oe_o = oe_q;

  p_drive_steady_high_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && scl_prev_i) |-> $stable(oe_q));

  p_stop_to_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (st_q == S_IDLE && !oe_q));

  p_start_to_addr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (st_q == S_ADDR && cnt_q == 3'd0));

  p_ignore_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_IGNORE) |-> !oe_q);

  p_host_ack_released_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_READ_ACK) |-> !oe_q);

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs #(
  parameter int unsigned NUM_REGS    = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  RST_BASE    = 8'hA0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [1:0]            strap_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  import i2c_tgt_pkg::*;

  logic scl_lvl, scl_prv, sda_lvl, sda_prv;
  logic we;
  logic [PTR_W-1:0]  ptr, waddr;
  logic [BYTE_W-1:0] wdata, rdata;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .level_o(scl_lvl), .prev_o(scl_prv)
  );

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .level_o(sda_lvl), .prev_o(sda_prv)
  );

  i2c_tgt_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_i(scl_lvl), .scl_prev_i(scl_prv),
    .sda_i(sda_lvl), .sda_prev_i(sda_prv),
    .strap_i(strap_i), .rdata_i(rdata),
    .ptr_o(ptr), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .sda_oe_o(sda_oe_o)
  );

  i2c_tgt_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(BYTE_W), .ADDR_W(PTR_W), .RST_BASE(RST_BASE)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(ptr), .rdata_o(rdata), .regs_o(cfg_o)
  );

endmodule

// File: tb/tb_i2c_tgt_regs.sv
`timescale 1ns/100ps
module tb_i2c_tgt_regs;

  localparam int Q = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic host_sda = 1'b1;
  logic [1:0] strap = 2'b01;
  logic sda_oe;
  logic [31:0] cfg;
  logic sda_bus;

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] exp_r [4];

  assign sda_bus = host_sda & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_tgt_regs dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .strap_i(strap), .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cfg();
    return {exp_r[3], exp_r[2], exp_r[1], exp_r[0]};
  endfunction

  task automatic clk_bit(input logic d, output logic e, output logic l);
    host_sda = d;
    #Q scl = 1'b1;
    #10 e = sda_bus;
    #(2*Q-20) l = sda_bus;
    #10 scl = 1'b0;
    #Q;
  endtask

  task automatic bus_start();   // from idle: SCL and SDA high
    #Q host_sda = 1'b0;
    #Q scl = 1'b0;
    #Q;
  endtask

  task automatic bus_rstart();  // from SCL low
    host_sda = 1'b1;
    #Q scl = 1'b1;
    #Q host_sda = 1'b0;
    #Q scl = 1'b0;
    #Q;
  endtask

  task automatic bus_stop();    // from SCL low
    host_sda = 1'b0;
    #Q scl = 1'b1;
    #Q host_sda = 1'b1;
    #Q;
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic e, l;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], e, l);
    clk_bit(1'b1, e, l);
    ack = !e && !l;
  endtask

  task automatic get_byte(input logic hack, output logic [7:0] b, output logic steady);
    logic e, l;
    steady = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, e, l);
      b[i] = l;
      if (e != l) steady = 1'b0;
    end
    clk_bit(hack ? 1'b0 : 1'b1, e, l);
  endtask

  function automatic logic [7:0] dev(input logic rd);
    return {4'b1001, strap, 1'b0, rd};
  endfunction

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 sda_oe after reset", 32'(sda_oe), 32'h0);
    chk(cfg == 32'hA3A2A1A0, "R1 reset values", cfg, 32'hA3A2A1A0);
  endtask

  task automatic t_write_basic();
    logic a;
    strap = 2'b01;
    bus_start();
    put_byte(dev(1'b0), a); chk(a, "R3 address ack (write)", 32'(a), 32'h1);
    put_byte(8'h01, a);     chk(a, "R5 pointer byte ack", 32'(a), 32'h1);
    put_byte(8'h5A, a);     chk(a, "R5 data ack", 32'(a), 32'h1);
    put_byte(8'hC3, a);     chk(a, "R5 data ack 2", 32'(a), 32'h1);
    bus_stop();
    exp_r[1] = 8'h5A; exp_r[2] = 8'hC3;
    chk(cfg == exp_cfg(), "R5 auto-increment write", cfg, exp_cfg());
  endtask

  task automatic t_read_rstart();
    logic a, s; logic [7:0] d;
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'h00, a);
    bus_rstart();
    put_byte(dev(1'b1), a); chk(a, "R3 address ack (read)", 32'(a), 32'h1);
    get_byte(1'b1, d, s);   chk(d == exp_r[0], "R9 pointer kept across repeated START", 32'(d), 32'(exp_r[0]));
    chk(s, "R10 read bits steady in SCL high", 32'(s), 32'h1);
    get_byte(1'b1, d, s);   chk(d == exp_r[1], "R7 read increments", 32'(d), 32'(exp_r[1]));
    get_byte(1'b0, d, s);   chk(d == exp_r[2], "R7 read third byte", 32'(d), 32'(exp_r[2]));
    get_byte(1'b0, d, s);   chk(d == 8'hFF, "R7 released after NACK", 32'(d), 32'hFF);
    bus_stop();
    // pointer now 3: new read without pointer byte
    bus_start();
    put_byte(dev(1'b1), a);
    get_byte(1'b1, d, s);   chk(d == exp_r[3], "R7 read from current pointer", 32'(d), 32'(exp_r[3]));
    get_byte(1'b0, d, s);   chk(d == 8'h00, "R8 unimplemented reads zero", 32'(d), 32'h0);
    bus_stop();
  endtask

  task automatic t_unimpl_write();
    logic a;
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'h03, a);
    put_byte(8'h77, a);
    put_byte(8'h99, a);     chk(a, "R6 unimplemented write acked", 32'(a), 32'h1);
    bus_stop();
    exp_r[3] = 8'h77;
    chk(cfg == exp_cfg(), "R6 unimplemented write dropped", cfg, exp_cfg());
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'hFF, a);
    put_byte(8'h11, a);
    put_byte(8'h22, a);
    bus_stop();
    exp_r[0] = 8'h22;
    chk(cfg == exp_cfg(), "R5 pointer wraps 255 to 0", cfg, exp_cfg());
  endtask

  task automatic t_mismatch();
    logic a, s; logic [7:0] d;
    strap = 2'b01;
    bus_start();
    put_byte(8'b1001_100_0, a); chk(!a, "R4 wrong strap not acked", 32'(a), 32'h0);
    put_byte(8'h00, a);         chk(!a, "R4 ignored after mismatch", 32'(a), 32'h0);
    put_byte(8'h55, a);
    bus_stop();
    chk(cfg == exp_cfg(), "R4 no write after mismatch", cfg, exp_cfg());
    bus_start();
    put_byte(8'h00, a);         chk(!a, "R4 general call rejected", 32'(a), 32'h0);
    bus_stop();
    bus_start();
    put_byte(8'b1111_000_0, a); chk(!a, "R4 ten-bit prefix rejected", 32'(a), 32'h0);
    bus_stop();
    bus_start();
    put_byte(8'b1001_100_1, a);
    get_byte(1'b0, d, s);       chk(d == 8'hFF, "R4 mismatched read drives nothing", 32'(d), 32'hFF);
    bus_stop();
    strap = 2'b10;
    bus_start();
    put_byte(8'b1001_100_0, a); chk(a, "R3 strap selects address", 32'(a), 32'h1);
    bus_stop();
    strap = 2'b01;
  endtask

  task automatic t_stop_idle();
    logic a;
    #Q scl = 1'b0;
    #Q;
    put_byte(dev(1'b0), a); chk(!a, "R11 no response without START", 32'(a), 32'h0);
    put_byte(8'h01, a);
    put_byte(8'h00, a);
    bus_stop();
    chk(cfg == exp_cfg(), "R11 idle writes nothing", cfg, exp_cfg());
  endtask

  task automatic t_abort();
    logic a, e, l;
    bus_start();
    put_byte(dev(1'b0), a);
    put_byte(8'h01, a);
    clk_bit(1'b0, e, l); clk_bit(1'b1, e, l); clk_bit(1'b1, e, l); clk_bit(1'b0, e, l);
    bus_rstart();
    put_byte(dev(1'b0), a); chk(a, "R2 START mid-byte restarts address", 32'(a), 32'h1);
    put_byte(8'h00, a);
    clk_bit(1'b0, e, l); clk_bit(1'b0, e, l); clk_bit(1'b1, e, l);
    bus_stop();
    chk(cfg == exp_cfg(), "R2 cut bytes discarded", cfg, exp_cfg());
    bus_start();
    put_byte(dev(1'b0), a); chk(a, "R2 usable after STOP mid-byte", 32'(a), 32'h1);
    put_byte(8'h00, a);
    put_byte(8'h3C, a);
    bus_stop();
    exp_r[0] = 8'h3C;
    chk(cfg == exp_cfg(), "R2 write after abort", cfg, exp_cfg());
  endtask

  initial begin
    for (int i = 0; i < 4; i++) exp_r[i] = 8'(8'hA0 + i);
    #101 rst_n = 1'b1;
    #100;
    t_reset();
    t_write_basic();
    t_read_rstart();
    t_unimpl_write();
    t_mismatch();
    t_stop_idle();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    #750000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

endmodule